// File: doc/BRIEF.md
# Key-Sequenced Watchdog Register Front End

This block is the software-facing side of a two-stage watchdog. It holds every setting that the countdown core needs: two 20-bit preload counts, the clock-scale choice, the interrupt kind raised at the end of the first stage, the reboot-on-expiry enable, the free-run setting and the enable. It also holds a previous-reboot flag that the core sets when a second-stage expiry causes a reboot. It tells the core when to restart stage 1 and when the flag has been cleared.

Software reaches it through two paths. The first is a 16-byte memory window addressed by byte offset. It takes byte, halfword and word accesses, with the write value right-aligned on `mm_wdata`. The second is a pair of configuration registers: a control word and a lock byte. The preload and restart registers in the window are guarded. Software must first write 0x80 and then 0x86 to offset 0xC. After that, exactly one guarded write is taken. The lock byte has a sticky lock bit. Once it is set, the byte is frozen until the block reset.

There are two resets. `rst` is the watchdog reset and returns all settings to their defaults. `por` is the power-on reset and is the only reset that clears the previous-reboot flag. Both resets are synchronous and active high. Writes act at the clock edge where they are presented. The restart and clear pulses are registered, so they are high for the one cycle that follows the write. Reads are combinational.

Top module: `wdreg_front`

## Requirements
- R1: After `rst`, the outputs are as follows: both preloads are 0xFFFFF, `reboot_en`=1, `fast_scale`=0, `irq_kind`=0, `free_run`=0, `wd_enable`=0 and `locked`=0. The key sequence is also back at its idle step.
- R2: Writing 0x80 of any size to offset 0xC moves the key sequence to its middle step. A following write of 0x86 to offset 0xC opens it. A 0x86 write given at any other step does not open it.
- R3: While the sequence is open, the next halfword or word write is consumed, whatever its offset, unless it is an 0x80 write to offset 0xC. The sequence then returns to idle. A second guarded write without a new key sequence has no effect.
- R4: An open word write to offset 0x0 loads `preload1`, and one to offset 0x4 loads `preload2`. Each keeps only the low 20 bits of the value. Preloads change by no other write.
- R5: An open halfword write to offset 0xC with bit 8 set raises `reload_pulse` for one cycle.
- R6: In that same open halfword write, bit 9 or bit 12 clears the previous-reboot flag and raises `clear_flag_pulse` for one cycle.
- R7: A halfword read of offset 0xC returns 0x1200 while the flag is set, and 0 otherwise. Every other read of the window returns 0.
- R8: Byte writes only step the key sequence. They never change a preload, never pulse the outputs and never consume an open sequence.
- R9: The lock byte has lock at bit 0, enable at bit 1 and free-run at bit 2. Once lock is set, lock-byte writes are ignored until `rst`.
- R10: The control word has reboot-disable at bit 5, fast scale at bit 2 and the interrupt kind at bits 1:0 (0 = IRQ, 2 = SMI, 3 = none). Both configuration registers read back in the encoding they were written with.
- R11: A lock-byte write that takes `wd_enable` from 0 to 1 raises `reload_pulse` for one cycle.
- R12: `reboot_flag_set` sets the previous-reboot flag. Only `por` or an R6 write clears it, and `rst` leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Watchdog reset, synchronous, active high |
| por | input | 1 | Power-on reset; clears the previous-reboot flag |
| mm_valid | input | 1 | Window access strobe |
| mm_write | input | 1 | 1 = write, 0 = read |
| mm_addr | input | 4 | Byte offset in the window |
| mm_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| mm_wdata | input | 32 | Right-aligned write value |
| mm_rdata | output | 32 | Read value (combinational) |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 1 | 0 = control word, 1 = lock byte |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read value (combinational) |
| reboot_flag_set | input | 1 | From the core: a second-stage reboot occurred |
| preload1 | output | 20 | Stage-1 count |
| preload2 | output | 20 | Stage-2 count |
| reboot_en | output | 1 | Reboot on second-stage expiry |
| fast_scale | output | 1 | Fast tick scale selected |
| irq_kind | output | 2 | Stage-1 interrupt kind |
| free_run | output | 1 | Restart stage 1 after second-stage expiry |
| wd_enable | output | 1 | Watchdog enabled |
| locked | output | 1 | Lock byte frozen |
| reload_pulse | output | 1 | Restart stage 1 |
| clear_flag_pulse | output | 1 | Previous-reboot flag cleared |

## Verification
The key-sequence step is the only hidden state. A wrong step never shows on its own. It shows at the next halfword or word write, which either changes a preload or pulses an output when it should not, or fails to do so when it should. The result is visible one cycle after that write. A flag that was lost or set by mistake shows at the next halfword read of offset 0xC. A lock bit in the wrong state shows as lock-byte read-back that differs from the write one cycle after the write. The bench therefore tracks the expected key step through long random write streams and checks the preloads and pulses after every single write.

// File: rtl/wdreg_pkg.sv
package wdreg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_MID  = 2'd1,
        SEQ_OPEN = 2'd2
    } seq_state_t;

    localparam logic [3:0] OFF_PRE1 = 4'h0;
    localparam logic [3:0] OFF_PRE2 = 4'h4;
    localparam logic [3:0] OFF_KEY  = 4'hC;
    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;
    localparam int         BIT_RESTART = 8;
    localparam int         BIT_CLR_A   = 9;
    localparam int         BIT_CLR_B   = 12;
    localparam logic [31:0] FLAG_READ  = 32'h0000_1200;

    typedef struct packed {
        logic       reboot_dis;
        logic       fast;
        logic [1:0] irq;
    } ctl_word_t;

    typedef struct packed {
        logic free_run;
        logic enable;
        logic lock;
    } lock_byte_t;

    function automatic logic [31:0] size_mask(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            SZ_BYTE: size_mask = {24'd0, d[7:0]};
            SZ_HALF: size_mask = {16'd0, d[15:0]};
            default: size_mask = d;
        endcase
    endfunction

endpackage

// File: rtl/wdreg_unlock.sv
module wdreg_unlock
    import wdreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic        at_key,
    input  logic [1:0]  size,
    input  logic [31:0] value,
    output logic        open,
    output logic        accept
);
    seq_state_t state;
    logic hit_first, hit_second;

    always_comb begin
        hit_first  = wr && at_key && (value == {24'd0, KEY_FIRST});
        hit_second = wr && at_key && (value == {24'd0, KEY_SECOND}) && (state == SEQ_MID);
        accept     = wr && !hit_first && !hit_second && (size != SZ_BYTE) && (state == SEQ_OPEN);
        open       = (state == SEQ_OPEN);
    end

    always_ff @(posedge clk) begin
        if (rst)             state <= SEQ_IDLE;
        else if (hit_first)  state <= SEQ_MID;
        else if (hit_second) state <= SEQ_OPEN;
        else if (accept)     state <= SEQ_IDLE;
    end
endmodule

// File: rtl/wdreg_ctrl.sv
module wdreg_ctrl
    import wdreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctl,
    input  logic       wr_lock,
    input  logic [7:0] wdata,
    output ctl_word_t  ctl,
    output lock_byte_t lk,
    output logic       en_rise
);
    lock_byte_t lk_new;

    always_comb begin
        lk_new  = lock_byte_t'(wdata[2:0]);
        en_rise = wr_lock && !lk.lock && !lk.enable && lk_new.enable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '{reboot_dis: 1'b0, fast: 1'b0, irq: 2'd0};
            lk  <= '{free_run: 1'b0, enable: 1'b0, lock: 1'b0};
        end else begin
            if (wr_ctl) begin
                ctl.reboot_dis <= wdata[5];
                ctl.fast       <= wdata[2];
                ctl.irq        <= wdata[1:0];
            end
            if (wr_lock && !lk.lock)
                lk <= lk_new;
        end
    end
endmodule

// File: rtl/wdreg_prot.sv
module wdreg_prot
    import wdreg_pkg::*;
#(
    parameter int PRELOAD_W = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por,
    input  logic                 accept,
    input  logic [3:0]           addr,
    input  logic [1:0]           size,
    input  logic [31:0]          value,
    input  logic                 en_rise,
    input  logic                 flag_set,
    output logic [PRELOAD_W-1:0] pre1,
    output logic [PRELOAD_W-1:0] pre2,
    output logic                 restart,
    output logic                 cleared,
    output logic                 flag
);
    localparam logic [PRELOAD_W-1:0] PRE_RESET = '1;
    logic key_half, do_restart, do_clear;

    always_comb begin
        key_half   = accept && (size == SZ_HALF) && (addr == OFF_KEY);
        do_restart = (key_half && value[BIT_RESTART]) || en_rise;
        do_clear   = key_half && (value[BIT_CLR_A] || value[BIT_CLR_B]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre1    <= PRE_RESET;
            pre2    <= PRE_RESET;
            restart <= 1'b0;
            cleared <= 1'b0;
        end else begin
            if (accept && size == SZ_WORD && addr == OFF_PRE1) pre1 <= value[PRELOAD_W-1:0];
            if (accept && size == SZ_WORD && addr == OFF_PRE2) pre2 <= value[PRELOAD_W-1:0];
            restart <= do_restart;
            cleared <= do_clear;
        end
    end

    always_ff @(posedge clk) begin
        if (por)           flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (do_clear) flag <= 1'b0;
    end
endmodule

// File: rtl/wdreg_front.sv
module wdreg_front
    import wdreg_pkg::*;
#(
    parameter int PRELOAD_W = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por,
    input  logic                 mm_valid,
    input  logic                 mm_write,
    input  logic [3:0]           mm_addr,
    input  logic [1:0]           mm_size,
    input  logic [31:0]          mm_wdata,
    output logic [31:0]          mm_rdata,
    input  logic                 cfg_valid,
    input  logic                 cfg_write,
    input  logic                 cfg_sel,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic                 reboot_flag_set,
    output logic [PRELOAD_W-1:0] preload1,
    output logic [PRELOAD_W-1:0] preload2,
    output logic                 reboot_en,
    output logic                 fast_scale,
    output logic [1:0]           irq_kind,
    output logic                 free_run,
    output logic                 wd_enable,
    output logic                 locked,
    output logic                 reload_pulse,
    output logic                 clear_flag_pulse
);
    logic [31:0] value;
    logic        mm_wr, seq_open, accept, en_rise, flag;
    ctl_word_t   ctl;
    lock_byte_t  lk;

    assign value = size_mask(mm_size, mm_wdata);
    assign mm_wr = mm_valid && mm_write;

    wdreg_unlock u_seq (
        .clk(clk), .rst(rst), .wr(mm_wr), .at_key(mm_addr == OFF_KEY),
        .size(mm_size), .value(value), .open(seq_open), .accept(accept)
    );

    wdreg_ctrl u_ctl (
        .clk(clk), .rst(rst),
        .wr_ctl(cfg_valid && cfg_write && !cfg_sel),
        .wr_lock(cfg_valid && cfg_write && cfg_sel),
        .wdata(cfg_wdata), .ctl(ctl), .lk(lk), .en_rise(en_rise)
    );

    wdreg_prot #(.PRELOAD_W(PRELOAD_W)) u_prot (
        .clk(clk), .rst(rst), .por(por), .accept(accept), .addr(mm_addr),
        .size(mm_size), .value(value), .en_rise(en_rise), .flag_set(reboot_flag_set),
        .pre1(preload1), .pre2(preload2), .restart(reload_pulse),
        .cleared(clear_flag_pulse), .flag(flag)
    );

    always_comb begin
        mm_rdata = '0;
        if (mm_valid && !mm_write && mm_size == SZ_HALF && mm_addr == OFF_KEY && flag)
            mm_rdata = FLAG_READ;
        cfg_rdata = '0;
        if (cfg_sel) cfg_rdata[2:0] = lk;
        else         cfg_rdata = {2'b00, ctl.reboot_dis, 2'b00, ctl.fast, ctl.irq};
    end

    assign reboot_en  = !ctl.reboot_dis;
    assign fast_scale = ctl.fast;
    assign irq_kind   = ctl.irq;
    assign free_run   = lk.free_run;
    assign wd_enable  = lk.enable;
    assign locked     = lk.lock;
endmodule

// File: rtl/wdreg_front_chk.sv
module wdreg_front_chk #(
    parameter int PRELOAD_W = 20
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mm_valid,
    input logic                 mm_write,
    input logic [3:0]           mm_addr,
    input logic [1:0]           mm_size,
    input logic [31:0]          mm_rdata,
    input logic                 cfg_valid,
    input logic                 cfg_write,
    input logic                 cfg_sel,
    input logic [PRELOAD_W-1:0] preload1,
    input logic [PRELOAD_W-1:0] preload2,
    input logic                 free_run,
    input logic                 wd_enable,
    input logic                 locked,
    input logic                 clear_flag_pulse,
    input logic                 seq_open
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R9
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (locked && cfg_valid && cfg_write && cfg_sel) |=> ($stable(wd_enable) && $stable(free_run))); // R9
    AST_BYTE_INERT: assert property (@(posedge clk) disable iff (rst)
        (mm_valid && mm_write && mm_size == 2'd0) |=>
        (!clear_flag_pulse && $stable(preload1) && $stable(preload2))); // R8
    AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mm_valid && !mm_write && !(mm_size == 2'd1 && mm_addr == 4'hC)) |-> (mm_rdata == 32'd0)); // R7
    AST_READ_FLAG: assert property (@(posedge clk) disable iff (rst)
        (mm_valid && !mm_write && mm_size == 2'd1 && mm_addr == 4'hC) |->
        (mm_rdata == 32'd0 || mm_rdata == 32'h1200)); // R7
    AST_PRELOAD_GATED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($stable(preload1) && $stable(preload2))) |-> $past(seq_open)); // R4
    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        clear_flag_pulse |=> !clear_flag_pulse); // R6
endmodule

bind wdreg_front wdreg_front_chk #(.PRELOAD_W(PRELOAD_W)) u_chk (
    .clk(clk), .rst(rst), .mm_valid(mm_valid), .mm_write(mm_write),
    .mm_addr(mm_addr), .mm_size(mm_size), .mm_rdata(mm_rdata),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_sel(cfg_sel),
    .preload1(preload1), .preload2(preload2), .free_run(free_run),
    .wd_enable(wd_enable), .locked(locked),
    .clear_flag_pulse(clear_flag_pulse), .seq_open(seq_open)
);

// File: tb/sim_wdreg_front.sv
module sim_wdreg_front;
    logic        clk = 1'b0;
    logic        rst, por, mm_valid, mm_write, cfg_valid, cfg_write, cfg_sel, reboot_flag_set;
    logic [3:0]  mm_addr;
    logic [1:0]  mm_size;
    logic [31:0] mm_wdata, mm_rdata;
    logic [7:0]  cfg_wdata, cfg_rdata;
    logic [19:0] preload1, preload2;
    logic        reboot_en, fast_scale, free_run, wd_enable, locked, reload_pulse, clear_flag_pulse;
    logic [1:0]  irq_kind;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int          m_st;
    logic [19:0] m_p1, m_p2;
    bit          m_flag;

    always #2.5 clk = ~clk;

    wdreg_front u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] vmask(input logic [1:0] s, input logic [31:0] d);
        if (s == 2'd0) return {24'd0, d[7:0]};
        if (s == 2'd1) return {16'd0, d[15:0]};
        return d;
    endfunction

    task automatic idle();
        mm_valid = 0; mm_write = 0; cfg_valid = 0; cfg_write = 0; reboot_flag_set = 0;
    endtask

    task automatic mm_wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d, input string req);
        logic [31:0] v;
        bit er, ec;
        v = vmask(s, d);
        er = 0; ec = 0;
        if (a == 4'hC && v == 32'h80) m_st = 1;
        else if (a == 4'hC && v == 32'h86 && m_st == 1) m_st = 2;
        else if (s != 2'd0 && m_st == 2) begin
            if (s == 2'd2 && a == 4'h0) m_p1 = v[19:0];
            if (s == 2'd2 && a == 4'h4) m_p2 = v[19:0];
            if (s == 2'd1 && a == 4'hC) begin
                er = v[8];
                if (v[9] || v[12]) begin ec = 1; m_flag = 0; end
            end
            m_st = 0;
        end
        mm_valid = 1; mm_write = 1; mm_addr = a; mm_size = s; mm_wdata = d;
        @(negedge clk);
        idle();
        chk(preload1 == m_p1, {req, " preload1"}, 32'(preload1), 32'(m_p1));
        chk(preload2 == m_p2, {req, " preload2"}, 32'(preload2), 32'(m_p2));
        chk(reload_pulse == er, {req, " reload_pulse"}, 32'(reload_pulse), 32'(er));
        chk(clear_flag_pulse == ec, {req, " clear_flag_pulse"}, 32'(clear_flag_pulse), 32'(ec));
    endtask

    task automatic mm_rd(input logic [3:0] a, input logic [1:0] s, input string req);
        logic [31:0] e;
        e = (a == 4'hC && s == 2'd1 && m_flag) ? 32'h1200 : 32'h0;
        mm_valid = 1; mm_write = 0; mm_addr = a; mm_size = s;
        #1;
        chk(mm_rdata == e, req, mm_rdata, e);
        @(negedge clk);
        idle();
    endtask

    task automatic cfg_wr(input bit sel, input logic [7:0] d);
        cfg_valid = 1; cfg_write = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic cfg_rd(input bit sel, input logic [7:0] e, input string req);
        cfg_valid = 1; cfg_write = 0; cfg_sel = sel;
        #1;
        chk(cfg_rdata == e, req, 32'(cfg_rdata), 32'(e));
        @(negedge clk);
        idle();
    endtask

    task automatic do_rst(input bit with_por);
        rst = 1; por = with_por;
        @(negedge clk);
        rst = 0; por = 0;
        m_st = 0; m_p1 = 20'hFFFFF; m_p2 = 20'hFFFFF;
        if (with_por) m_flag = 0;
    endtask

    task automatic unlock();
        mm_wr(4'hC, 2'd1, 32'h80, "R2 key1");
        mm_wr(4'hC, 2'd1, 32'h86, "R2 key2");
    endtask

    initial begin
        idle();
        mm_addr = 0; mm_size = 0; mm_wdata = 0; cfg_sel = 0; cfg_wdata = 0;
        rst = 1; por = 1;
        void'($urandom(32'd2024));
        @(negedge clk);
        do_rst(1);

        // R1 reset state
        chk(preload1 == 20'hFFFFF && preload2 == 20'hFFFFF, "R1 preloads", 32'(preload1), 32'hFFFFF);
        chk({reboot_en, fast_scale, irq_kind, free_run, wd_enable, locked} == 7'b1000000,
            "R1 controls", 32'({reboot_en, fast_scale, irq_kind, free_run, wd_enable, locked}), 32'h40);
        mm_rd(4'hC, 2'd1, "R1 R7 flag clear after por");

        // R2 and R4: word preload writes through the key sequence
        unlock();
        mm_wr(4'h0, 2'd2, 32'hABC12345, "R4 preload1 low 20 bits");
        unlock();
        mm_wr(4'h4, 2'd2, 32'h00054321, "R4 preload2");
        // R3: second guarded write without keys has no effect
        mm_wr(4'h0, 2'd2, 32'h11111, "R3 no second write");
        // R2: 0x86 without 0x80 does not open
        mm_wr(4'hC, 2'd1, 32'h86, "R2 lone key2");
        mm_wr(4'h0, 2'd2, 32'h22222, "R2 not open");
        // R8: byte keys step the sequence; byte writes do not consume it
        mm_wr(4'hC, 2'd0, 32'h80, "R8 byte key1");
        mm_wr(4'hC, 2'd0, 32'h86, "R8 byte key2");
        mm_wr(4'h0, 2'd0, 32'h55, "R8 byte inert");
        mm_wr(4'h4, 2'd2, 32'h33333, "R8 open after bytes");
        // R3: a consumed write at an unrelated offset closes the sequence
        unlock();
        mm_wr(4'h8, 2'd1, 32'h0100, "R3 consume other offset");
        mm_wr(4'hC, 2'd1, 32'h0100, "R3 closed restart");

        // R5 restart
        unlock();
        mm_wr(4'hC, 2'd1, 32'h0100, "R5 restart");
        // R12 flag set, R7 read, R6 clear via bit 9 then bit 12
        reboot_flag_set = 1; @(negedge clk); idle(); m_flag = 1;
        mm_rd(4'hC, 2'd1, "R12 R7 flag read");
        mm_rd(4'hC, 2'd2, "R7 word read zero");
        mm_rd(4'h0, 2'd1, "R7 other offset zero");
        do_rst(0);
        mm_rd(4'hC, 2'd1, "R12 flag survives rst");
        unlock();
        mm_wr(4'hC, 2'd1, 32'h0200, "R6 clear bit9");
        mm_rd(4'hC, 2'd1, "R6 flag cleared");
        reboot_flag_set = 1; @(negedge clk); idle(); m_flag = 1;
        unlock();
        mm_wr(4'hC, 2'd1, 32'h1100, "R6 R5 clear bit12 with restart");
        mm_rd(4'hC, 2'd1, "R6 flag cleared b12");

        // R10 control word
        cfg_wr(0, 8'h27);
        chk(!reboot_en && fast_scale && irq_kind == 2'd3, "R10 control decode",
            32'({reboot_en, fast_scale, irq_kind}), 32'h7);
        cfg_rd(0, 8'h27, "R10 control readback");
        cfg_wr(0, 8'h02);
        chk(reboot_en && !fast_scale && irq_kind == 2'd2, "R10 SMI kind",
            32'({reboot_en, fast_scale, irq_kind}), 32'hA);

        // R11 enable rise and R9 lock
        cfg_valid = 1; cfg_write = 1; cfg_sel = 1; cfg_wdata = 8'h06;
        @(negedge clk); idle();
        chk(reload_pulse == 1, "R11 enable rise restart", 32'(reload_pulse), 1);
        chk(wd_enable && free_run && !locked, "R9 lock byte fields", 32'({free_run, wd_enable, locked}), 6);
        @(negedge clk);
        chk(reload_pulse == 0, "R11 pulse one cycle", 32'(reload_pulse), 0);
        cfg_wr(1, 8'h03);
        cfg_rd(1, 8'h03, "R9 readback locked");
        cfg_wr(1, 8'h00);
        chk(wd_enable && locked && !free_run, "R9 frozen", 32'({free_run, wd_enable, locked}), 3);
        do_rst(0);
        chk(!locked && !wd_enable, "R1 R9 rst unlocks", 32'({wd_enable, locked}), 0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  a;
            logic [1:0]  s;
            logic [31:0] d;
            int k;
            a = 4'($urandom_range(0, 3) * 4);
            s = 2'($urandom_range(0, 2));
            k = $urandom_range(0, 4);
            if (k == 0) begin a = 4'hC; d = 32'h80; end
            else if (k == 1) begin a = 4'hC; d = 32'h86; end
            else d = $urandom;
            if ($urandom_range(0, 9) == 0) begin
                reboot_flag_set = 1; @(negedge clk); idle(); m_flag = 1;
            end
            mm_wr(a, s, d, "R3 R4 R5 R6 R8 random");
            if ((i % 16) == 0) mm_rd(4'hC, 2'd1, "R7 random read");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule